// File: doc/BRIEF.md
# Warp-Granular Block Admission Controller

This controller sits between a thread-block source and one streaming multiprocessor. Each cycle it looks at the kernel's per-block needs and at the multiprocessor's free resources. From these it decides whether the next block can be placed whole, placed in part, or not placed at all. The free resources are scheduler entries, block slots, registers and shared memory. A block is placed whole when every resource covers the entire block. When that fails but the shared memory and a slot are still there, a second check measured in warps admits a partial block. That block gets its shared memory in full, but only the warps that the free registers and scheduler entries can hold start at once.

The warps of a partial block that did not start wait in a single holding entry. They start one per cycle, in ascending warp id order, as completing warps hand back registers and scheduler entries. While that entry is occupied, no new block is accepted. Registers and scheduler entries are granted and returned per warp. A block's shared memory and its slot come back only when its last warp completes. Admission by warps, whether a partial grant or a held warp starting, stops once the number of resident warps reaches a fixed cap.

Top module: `wga_admit`

## Requirements
- R1: After reset the free counters read the full totals (32768 registers, 48 scheduler entries, 8 slots, 49152 shared-memory units) and no held warp is issued.
- R2: When the free shared memory, a slot, the free scheduler entries and the free registers all cover a whole block, `dec_kind` is 1 (full) and `grant_warps` equals `cfg_wpb`. An accepted full block takes `cfg_wpb*cfg_rpw` registers, `cfg_wpb` entries, one slot and `cfg_smem`, visible on the counters the cycle after acceptance.
- R3: When the whole-block check fails but shared memory and a slot are free, `dec_kind` is 2 (partial). `grant_warps` is then the smallest of floor(free registers / `cfg_rpw`), the free scheduler entries and the room left under the warp cap, provided that value is at least 1. An accepted partial block takes the whole `cfg_smem` but registers and entries for the granted warps only.
- R4: With too little shared memory, no free slot, no free scheduler entry or too few registers for one warp, `dec_kind` is 0 (none) and `req_ready` is low.
- R5: Warp-level admission (partial grants and held-warp issue) is allowed only while fewer than 36 warps are resident, and a partial grant never lifts residency above 36. Full blocks are not limited by this cap.
- R6: While the held entry is occupied, `req_ready` is low and `dec_kind` reads 0, so at most one partial block is resident.
- R7: A held warp issues (`iss_valid` high, with `iss_slot` and `iss_wid`) in any cycle when a scheduler entry, the block's per-warp registers and room under the cap are all free. Held warps issue one per cycle in ascending warp id, and the last one empties the entry.
- R8: A `wdone_valid` pulse returns that block's per-warp registers and one scheduler entry, visible the cycle after the pulse.
- R9: A block's shared memory and slot are returned only with the completion of the last of its `cfg_wpb` warps, counting warps that were held.
- R10: The counters change only through an accepted request (`req_valid` and `req_ready`), an issued held warp or a completion. A request with `req_ready` low, or `req_valid` low, leaves them unchanged.
- R11: A block is placed in the lowest-numbered free slot, reported on `grant_slot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rpw | input | 12 | Registers per warp for the kernel |
| cfg_wpb | input | 6 | Warps per block (1 to 32) |
| cfg_smem | input | 16 | Shared memory per block |
| req_valid | input | 1 | Block source offers the next block |
| req_ready | output | 1 | Controller can place the offered block |
| dec_kind | output | 2 | 0 none, 1 full, 2 partial |
| grant_warps | output | 6 | Warps that start at placement |
| grant_slot | output | 3 | Slot the block will occupy |
| iss_valid | output | 1 | A held warp starts this cycle |
| iss_slot | output | 3 | Slot of the held warp |
| iss_wid | output | 5 | Warp id of the held warp |
| wdone_valid | input | 1 | One warp completed this cycle |
| wdone_slot | input | 3 | Slot of the completed warp |
| free_regs | output | 16 | Free registers |
| free_sched | output | 6 | Free scheduler entries |
| free_slots | output | 4 | Free block slots |
| free_smem | output | 16 | Free shared memory |

## Verification
`dec_kind`, `grant_warps`, `grant_slot`, `req_ready` and the held-warp issue fields are combinational on the registered counters and the configuration. The bench drives inputs on the falling edge and reads these a moment later, before the next rising edge. Counter effects of acceptances, issues and completions appear one rising edge later, so the bench reads them on the following falling edge. Because a held warp issues by itself whenever resources allow, each scenario checks the issue fields before the edge that consumes them and the counters after it.

// File: rtl/wga_pkg.sv
package wga_pkg;

  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_FULL = 2'd1,
    DEC_PART = 2'd2
  } dec_e;

  // warps whose registers fit into a pool; zero per-warp need fits "many"
  function automatic int unsigned warps_by_regs(int unsigned regs, int unsigned rpw);
    if (rpw == 0) return 32'hFFFF;
    return regs / rpw;
  endfunction

  function automatic int unsigned min3u(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // warps still admissible at warp granularity under the residency cap
  function automatic int unsigned cap_room(int unsigned active, int unsigned cap);
    return (active < cap) ? cap - active : 0;
  endfunction

endpackage

// File: rtl/wga_fit.sv
module wga_fit
  import wga_pkg::*;
#(
  parameter int MAX_WARPS = 48,
  parameter int WARP_CAP  = 36,
  parameter int RW        = 16,
  parameter int WW        = 6,
  parameter int SW        = 16,
  parameter int RPW_W     = 12,
  parameter int GW        = 6
) (
  input  logic [RW-1:0]    free_regs,
  input  logic [WW-1:0]    free_sched,
  input  logic [SW-1:0]    free_smem,
  input  logic             slot_avail,
  input  logic [RPW_W-1:0] cfg_rpw,
  input  logic [GW-1:0]    cfg_wpb,
  input  logic [SW-1:0]    cfg_smem,
  output dec_e             kind,
  output logic [GW-1:0]    grant,
  output logic [WW-1:0]    active
);

  int unsigned regs_u, need_u, fit_u, room_u, g_u;
  logic smem_ok, blk_ok, warp_ok;

  assign active = WW'(MAX_WARPS) - free_sched;

  always_comb begin
    regs_u  = 32'(free_regs);
    need_u  = 32'(cfg_wpb) * 32'(cfg_rpw);
    fit_u   = warps_by_regs(regs_u, 32'(cfg_rpw));
    room_u  = cap_room(32'(active), WARP_CAP);
    g_u     = min3u(fit_u, 32'(free_sched), room_u);
    smem_ok = (32'(cfg_smem) <= 32'(free_smem)) && slot_avail && (cfg_wpb != '0);
    blk_ok  = smem_ok && (32'(cfg_wpb) <= 32'(free_sched)) && (need_u <= regs_u);
    warp_ok = smem_ok && (g_u != 0);
    if (blk_ok) begin
      kind  = DEC_FULL;
      grant = cfg_wpb;
    end else if (warp_ok) begin
      kind  = DEC_PART;
      grant = GW'(g_u);
    end else begin
      kind  = DEC_NONE;
      grant = '0;
    end
  end

endmodule

// File: rtl/wga_slots.sv
module wga_slots #(
  parameter int NSLOT = 8,
  parameter int RPW_W = 12,
  parameter int SW    = 16,
  parameter int GW    = 6,
  localparam int SLW  = $clog2(NSLOT),
  localparam int CNTW = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [RPW_W-1:0] alloc_rpw,
  input  logic [SW-1:0]    alloc_smem,
  input  logic [GW-1:0]    alloc_live,
  input  logic             done,
  input  logic [SLW-1:0]   done_slot,
  output logic             any_free,
  output logic [SLW-1:0]   free_idx,
  output logic [CNTW-1:0]  free_cnt,
  output logic [RPW_W-1:0] rel_rpw,
  output logic             rel_last,
  output logic [SW-1:0]    rel_smem
);

  logic             busy_q [NSLOT];
  logic [RPW_W-1:0] rpw_q  [NSLOT];
  logic [SW-1:0]    smem_q [NSLOT];
  logic [GW-1:0]    live_q [NSLOT];
  logic [NSLOT-1:0] free_vec;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[g] <= 1'b0;
        rpw_q[g]  <= '0;
        smem_q[g] <= '0;
        live_q[g] <= '0;
      end else if (alloc && any_free && free_idx == SLW'(g)) begin
        busy_q[g] <= 1'b1;
        rpw_q[g]  <= alloc_rpw;
        smem_q[g] <= alloc_smem;
        live_q[g] <= alloc_live;
      end else if (done && done_slot == SLW'(g) && busy_q[g]) begin
        live_q[g] <= live_q[g] - GW'(1);
        if (live_q[g] == GW'(1)) busy_q[g] <= 1'b0;
      end
    end
  end

  // lowest-numbered free slot wins
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      free_vec[i] = !busy_q[i];
      if (!busy_q[i]) begin
        any_free = 1'b1;
        free_idx = SLW'(i);
      end
    end
  end

  assign free_cnt = CNTW'($countones(free_vec));
  assign rel_rpw  = rpw_q[done_slot];
  assign rel_smem = smem_q[done_slot];
  assign rel_last = done && busy_q[done_slot] && (live_q[done_slot] == GW'(1));

  a_r9_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_q[done_slot] && live_q[done_slot] == GW'(1)) |=> !busy_q[$past(done_slot)]);

  a_r9_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy_q[done_slot] && live_q[done_slot] > GW'(1)) |=> busy_q[$past(done_slot)]);

endmodule

// File: rtl/wga_pend.sv
module wga_pend #(
  parameter int SLW   = 3,
  parameter int WID_W = 5,
  parameter int RPW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SLW-1:0]   load_slot,
  input  logic [WID_W-1:0] load_first,
  input  logic [WID_W-1:0] load_last,
  input  logic [RPW_W-1:0] load_rpw,
  input  logic             can_go,
  output logic             pend_valid,
  output logic             iss_valid,
  output logic [SLW-1:0]   iss_slot,
  output logic [WID_W-1:0] iss_wid,
  output logic [RPW_W-1:0] pend_rpw
);

  logic             v_q;
  logic [SLW-1:0]   slot_q;
  logic [WID_W-1:0] nxt_q, last_q;
  logic [RPW_W-1:0] rpw_q;

  assign pend_valid = v_q;
  assign iss_valid  = v_q && can_go;
  assign iss_slot   = slot_q;
  assign iss_wid    = nxt_q;
  assign pend_rpw   = rpw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      slot_q <= '0;
      nxt_q  <= '0;
      last_q <= '0;
      rpw_q  <= '0;
    end else if (load) begin
      v_q    <= 1'b1;
      slot_q <= load_slot;
      nxt_q  <= load_first;
      last_q <= load_last;
      rpw_q  <= load_rpw;
    end else if (iss_valid) begin
      if (nxt_q == last_q) v_q <= 1'b0;
      else                 nxt_q <= nxt_q + WID_W'(1);
    end
  end

  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !v_q);

  a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_wid != last_q) |=> (pend_valid && iss_wid == $past(iss_wid) + WID_W'(1)));

endmodule

// File: rtl/wga_admit.sv
module wga_admit
  import wga_pkg::*;
#(
  parameter int NSLOT      = 8,
  parameter int MAX_WARPS  = 48,
  parameter int MAX_WPB    = 32,
  parameter int REG_TOTAL  = 32768,
  parameter int SMEM_TOTAL = 49152,
  parameter int WARP_CAP   = 36,
  parameter int RPW_W      = 12,
  localparam int RW    = $clog2(REG_TOTAL + 1),
  localparam int WW    = $clog2(MAX_WARPS + 1),
  localparam int SW    = $clog2(SMEM_TOTAL + 1),
  localparam int GW    = $clog2(MAX_WPB + 1),
  localparam int WID_W = $clog2(MAX_WPB),
  localparam int SLW   = $clog2(NSLOT),
  localparam int CNTW  = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RPW_W-1:0] cfg_rpw,
  input  logic [GW-1:0]    cfg_wpb,
  input  logic [SW-1:0]    cfg_smem,
  input  logic             req_valid,
  output logic             req_ready,
  output logic [1:0]       dec_kind,
  output logic [GW-1:0]    grant_warps,
  output logic [SLW-1:0]   grant_slot,
  output logic             iss_valid,
  output logic [SLW-1:0]   iss_slot,
  output logic [WID_W-1:0] iss_wid,
  input  logic             wdone_valid,
  input  logic [SLW-1:0]   wdone_slot,
  output logic [RW-1:0]    free_regs,
  output logic [WW-1:0]    free_sched,
  output logic [CNTW-1:0]  free_slots,
  output logic [SW-1:0]    free_smem
);

  logic [RW-1:0]    free_regs_q;
  logic [WW-1:0]    free_sched_q;
  logic [SW-1:0]    free_smem_q;
  dec_e             kind, dec_out;
  logic [GW-1:0]    grant, grant_out;
  logic [WW-1:0]    active;
  logic             any_free, rel_last, pend_valid, can_go, fire, load_part;
  logic [SLW-1:0]   free_idx;
  logic [RPW_W-1:0] rel_rpw, pend_rpw;
  logic [SW-1:0]    rel_smem;
  int unsigned      rel_r, alloc_r, rel_w, alloc_w, rel_s, alloc_s;

  wga_fit #(
    .MAX_WARPS(MAX_WARPS), .WARP_CAP(WARP_CAP), .RW(RW), .WW(WW),
    .SW(SW), .RPW_W(RPW_W), .GW(GW)
  ) u_fit (
    .free_regs (free_regs_q),
    .free_sched(free_sched_q),
    .free_smem (free_smem_q),
    .slot_avail(any_free),
    .cfg_rpw   (cfg_rpw),
    .cfg_wpb   (cfg_wpb),
    .cfg_smem  (cfg_smem),
    .kind      (kind),
    .grant     (grant),
    .active    (active)
  );

  // a held partial block freezes new placement
  assign dec_out     = pend_valid ? DEC_NONE : kind;
  assign grant_out   = pend_valid ? '0 : grant;
  assign req_ready   = (dec_out != DEC_NONE);
  assign fire        = req_valid && req_ready;
  assign load_part   = fire && (dec_out == DEC_PART);
  assign dec_kind    = dec_out;
  assign grant_warps = grant_out;
  assign grant_slot  = free_idx;

  assign can_go = (free_sched_q != '0) && (32'(free_regs_q) >= 32'(pend_rpw))
                  && (32'(active) < WARP_CAP);

  wga_slots #(
    .NSLOT(NSLOT), .RPW_W(RPW_W), .SW(SW), .GW(GW)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (fire),
    .alloc_rpw (cfg_rpw),
    .alloc_smem(cfg_smem),
    .alloc_live(cfg_wpb),
    .done      (wdone_valid),
    .done_slot (wdone_slot),
    .any_free  (any_free),
    .free_idx  (free_idx),
    .free_cnt  (free_slots),
    .rel_rpw   (rel_rpw),
    .rel_last  (rel_last),
    .rel_smem  (rel_smem)
  );

  wga_pend #(
    .SLW(SLW), .WID_W(WID_W), .RPW_W(RPW_W)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_part),
    .load_slot (free_idx),
    .load_first(WID_W'(grant_out)),
    .load_last (WID_W'(cfg_wpb - GW'(1))),
    .load_rpw  (cfg_rpw),
    .can_go    (can_go),
    .pend_valid(pend_valid),
    .iss_valid (iss_valid),
    .iss_slot  (iss_slot),
    .iss_wid   (iss_wid),
    .pend_rpw  (pend_rpw)
  );

  always_comb begin
    rel_r   = wdone_valid ? 32'(rel_rpw) : 0;
    rel_w   = wdone_valid ? 1 : 0;
    rel_s   = rel_last ? 32'(rel_smem) : 0;
    alloc_r = fire ? 32'(grant_out) * 32'(cfg_rpw) : (iss_valid ? 32'(pend_rpw) : 0);
    alloc_w = fire ? 32'(grant_out) : (iss_valid ? 1 : 0);
    alloc_s = fire ? 32'(cfg_smem) : 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_regs_q  <= RW'(REG_TOTAL);
      free_sched_q <= WW'(MAX_WARPS);
      free_smem_q  <= SW'(SMEM_TOTAL);
    end else begin
      free_regs_q  <= RW'(32'(free_regs_q) + rel_r - alloc_r);
      free_sched_q <= WW'(32'(free_sched_q) + rel_w - alloc_w);
      free_smem_q  <= SW'(32'(free_smem_q) + rel_s - alloc_s);
    end
  end

  assign free_regs  = free_regs_q;
  assign free_sched = free_sched_q;
  assign free_smem  = free_smem_q;

  a_r1_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_regs_q) <= REG_TOTAL) && (32'(free_sched_q) <= MAX_WARPS)
    && (32'(free_smem_q) <= SMEM_TOTAL));

  a_r2_full_all_warps: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_out == DEC_FULL) |-> grant_warps == cfg_wpb);

  a_r3_partial_short: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out == DEC_PART) |-> (grant_warps != '0 && grant_warps < cfg_wpb));

  a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out == DEC_PART) |-> (32'(active) + 32'(grant_warps) <= WARP_CAP));

  a_r6_single_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec_out == DEC_PART) |=> !req_ready);

  a_r7_issue_takes_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !wdone_valid) |=> free_sched_q == $past(free_sched_q) - WW'(1));

  a_r8_return_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (wdone_valid && !fire && !iss_valid) |=> free_sched_q == $past(free_sched_q) + WW'(1));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !iss_valid && !wdone_valid) |=>
      ($stable(free_regs_q) && $stable(free_sched_q) && $stable(free_smem_q)));

endmodule

// File: tb/wga_admit_tb.sv
`timescale 1ns/1ps
module wga_admit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_rpw = '0;
  logic [5:0]  cfg_wpb = '0;
  logic [15:0] cfg_smem = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  dec_kind;
  logic [5:0]  grant_warps;
  logic [2:0]  grant_slot;
  logic        iss_valid;
  logic [2:0]  iss_slot;
  logic [4:0]  iss_wid;
  logic        wdone_valid = 1'b0;
  logic [2:0]  wdone_slot = '0;
  logic [15:0] free_regs;
  logic [5:0]  free_sched;
  logic [3:0]  free_slots;
  logic [15:0] free_smem;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wga_admit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rpw(cfg_rpw), .cfg_wpb(cfg_wpb), .cfg_smem(cfg_smem),
    .req_valid(req_valid), .req_ready(req_ready), .dec_kind(dec_kind),
    .grant_warps(grant_warps), .grant_slot(grant_slot), .iss_valid(iss_valid),
    .iss_slot(iss_slot), .iss_wid(iss_wid), .wdone_valid(wdone_valid),
    .wdone_slot(wdone_slot), .free_regs(free_regs), .free_sched(free_sched),
    .free_slots(free_slots), .free_smem(free_smem)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; req_valid = 1'b0; wdone_valid = 1'b0; wdone_slot = '0;
    step; step;
    rst_n = 1'b1;
    step;
  endtask

  task automatic set_cfg(int r, int w, int s);
    cfg_rpw = 12'(r); cfg_wpb = 6'(w); cfg_smem = 16'(s);
    #1;
  endtask

  task automatic fire;
    req_valid = 1'b1;
    #1;
    step;
    req_valid = 1'b0;
    #1;
  endtask

  task automatic done(int s);
    wdone_valid = 1'b1; wdone_slot = 3'(s);
    step;
    wdone_valid = 1'b0;
    #1;
  endtask

  task automatic counters(string tag, int r, int w, int sl, int sm);
    chk({tag, " free_regs"}, int'(free_regs), r);
    chk({tag, " free_sched"}, int'(free_sched), w);
    chk({tag, " free_slots"}, int'(free_slots), sl);
    chk({tag, " free_smem"}, int'(free_smem), sm);
  endtask

  task automatic t_reset;
    do_reset;
    counters("R1 reset", 32768, 48, 8, 49152);
    chk("R1 no issue", int'(iss_valid), 0);
  endtask

  // two full blocks, then a partial one, then held warps issue on completions
  task automatic t_partial_flow;
    do_reset;
    set_cfg(2048, 6, 8192);
    chk("R2 dec full", int'(dec_kind), 1);
    chk("R2 grant", int'(grant_warps), 6);
    chk("R11 slot0", int'(grant_slot), 0);
    fire;
    counters("R2 first", 20480, 42, 7, 40960);
    fire;
    counters("R2 second", 8192, 36, 6, 32768);
    chk("R3 dec partial", int'(dec_kind), 2);
    chk("R3 grant", int'(grant_warps), 4);
    chk("R11 slot2", int'(grant_slot), 2);
    fire;
    counters("R3 after", 0, 32, 5, 24576);
    chk("R6 ready low", int'(req_ready), 0);
    chk("R6 dec none", int'(dec_kind), 0);
    chk("R7 no regs no issue", int'(iss_valid), 0);
    done(0);
    counters("R8 return", 2048, 33, 5, 24576);
    chk("R7 issue", int'(iss_valid), 1);
    chk("R7 slot", int'(iss_slot), 2);
    chk("R7 wid4", int'(iss_wid), 4);
    step; #1;
    chk("R7 regs taken", int'(free_regs), 0);
    chk("R7 entry taken", int'(free_sched), 32);
    chk("R7 idle", int'(iss_valid), 0);
    done(1);
    chk("R7 wid5", int'(iss_wid), 5);
    chk("R7 issue2", int'(iss_valid), 1);
    step; #1;
    chk("R4 no regs ready", int'(req_ready), 0);
    chk("R7 cleared", int'(iss_valid), 0);
    done(2);
    chk("R3 dec partial 2", int'(dec_kind), 2);
    chk("R3 grant 1", int'(grant_warps), 1);
    chk("R11 slot3", int'(grant_slot), 3);
  endtask

  task automatic t_release;
    do_reset;
    set_cfg(64, 2, 1000);
    fire;
    counters("R2 small", 32640, 46, 7, 48152);
    done(0);
    counters("R9 not last", 32704, 47, 7, 48152);
    done(0);
    counters("R9 last", 32768, 48, 8, 49152);
  endtask

  task automatic t_refuse_and_slots;
    do_reset;
    set_cfg(64, 2, 60000);
    chk("R4 smem ready", int'(req_ready), 0);
    chk("R4 smem dec", int'(dec_kind), 0);
    req_valid = 1'b1;
    step;
    req_valid = 1'b0; #1;
    counters("R10 refused", 32768, 48, 8, 49152);
    set_cfg(16, 1, 0);
    chk("R10 ready", int'(req_ready), 1);
    step; #1;
    counters("R10 no valid", 32768, 48, 8, 49152);
    for (int i = 0; i < 8; i++) begin
      chk("R11 order", int'(grant_slot), i);
      fire;
    end
    chk("R4 no slot", int'(req_ready), 0);
    chk("R4 slots", int'(free_slots), 0);
    done(3);
    chk("R11 reuse", int'(grant_slot), 3);
    chk("R9 slot back", int'(free_slots), 1);
  endtask

  task automatic t_cap;
    do_reset;
    set_cfg(768, 8, 2048);
    for (int i = 0; i < 5; i++) fire;
    counters("R2 five", 2048, 8, 3, 38912);
    chk("R5 cap none", int'(dec_kind), 0);
    chk("R5 cap ready", int'(req_ready), 0);
    do_reset;
    set_cfg(256, 17, 0);
    fire; fire;
    chk("R5 dec partial", int'(dec_kind), 2);
    chk("R5 grant cap", int'(grant_warps), 2);
    fire;
    chk("R5 entries", int'(free_sched), 12);
    chk("R5 issue blocked", int'(iss_valid), 0);
    done(0);
    chk("R7 issue cap", int'(iss_valid), 1);
    chk("R7 wid2", int'(iss_wid), 2);
    chk("R7 slot2", int'(iss_slot), 2);
    step; #1;
    chk("R5 blocked again", int'(iss_valid), 0);
    chk("R5 entries2", int'(free_sched), 12);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_partial_flow;
    t_release;
    t_refuse_and_slots;
    t_cap;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule